// File: doc/BRIEF.md
# Speculative Task Ring Tracker

This block keeps the order of speculative tasks spread over a fixed ring of processing units. A sequencer asks for a unit for each new task, and the block gives it the unit just past the newest active task. Two pointers bracket the live tasks: the head marks the oldest task and the tail marks the newest. Both pointers wrap around the unit count.

Units report completion in any order, but a task retires only when it is at the head. Each retirement is shown for one cycle on a commit strobe together with the unit index. A unit that detects a wrong prediction or a bad data value requests a squash. That removes its own task and every younger task, and the tail moves back to the unit just before it. The outputs show the head and tail indices, the occupancy, full and empty flags, and a bitmap of the active units.

Top module: `spec_task_ring`

## Requirements
- R1: After reset the ring is empty. Head and tail both read unit 0, occupancy is 0, the active bitmap is all zero, and assign_ready is 1.
- R2: An accepted assign request (assign_valid and assign_ready both high at a clock edge) places the task on the unit shown on assign_unit. That unit is the head unit when the ring is empty, otherwise the tail unit plus one. After the edge that unit is the tail, its bit in `active` is 1 and occupancy has grown by one.
- R3: When occupancy equals the unit count, full is 1 and assign_ready is 0. An assign request in that state changes no output.
- R4: Unit indices wrap modulo the unit count: the unit after the highest index is unit 0, for both assignment and retirement.
- R5: A completion report (done_valid with done_unit) is recorded only for an active unit. commit_valid is 1 in any cycle where the head unit is active and has recorded completion, with commit_unit equal to head_unit. At the next edge the head moves to the next unit, that unit's active bit clears, and occupancy drops by one.
- R6: Completion of a unit that is not at the head produces no commit. That unit commits only after every older task has committed, one task per cycle in ring order.
- R7: A squash request naming an active unit k clears the active bits from k through the tail. The tail becomes the unit before k, and occupancy becomes the number of tasks older than k. If k is the head, the ring becomes empty, with the tail reading the head index.
- R8: In a cycle with an effective squash, commit_valid and assign_ready are 0, and head_unit is unchanged after the edge.
- R9: A squash request naming an inactive unit has no effect on any output.
- R10: empty is 1 exactly when occupancy is 0. Whenever the ring is not empty, the head unit's active bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| assign_valid | input | 1 | Sequencer requests a unit for a new task |
| assign_ready | output | 1 | A request would be accepted this cycle |
| assign_unit | output | log2(UNITS) | Unit that the next accepted task goes to |
| done_valid | input | 1 | A unit reports that its task has finished |
| done_unit | input | log2(UNITS) | Unit reporting completion |
| squash_valid | input | 1 | A unit requests a squash of itself and younger tasks |
| squash_unit | input | log2(UNITS) | Unit requesting the squash |
| commit_valid | output | 1 | The head task retires at this edge |
| commit_unit | output | log2(UNITS) | Unit of the retiring task |
| head_unit | output | log2(UNITS) | Oldest active unit |
| tail_unit | output | log2(UNITS) | Newest active unit; equals head_unit when empty |
| occupancy | output | log2(UNITS)+1 | Number of active tasks |
| full | output | 1 | Every unit holds a task |
| empty | output | 1 | No unit holds a task |
| active | output | UNITS | One bit per unit, set while it holds a task |

## Verification
The assertions assume that UNITS is a power of two of at least 2, so unit indices wrap by plain truncation. They also assume that each request input is a clean level, sampled once per edge, and carries no unknown values. The bench drives every request one time unit after a rising edge and drops it after the next edge. Each request therefore lasts exactly one cycle, and the done, squash and assign inputs are only combined on purpose in the priority scenario. The scoreboard stands in for the sequencer's own record of program order. Each accepted assignment is appended to it, each squash trims it from the young end, and each commit must match its oldest entry.

// File: rtl/spec_task_ring.sv
module spec_task_ring #(
  parameter int UNITS = 4,
  localparam int IW = $clog2(UNITS),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          assign_valid,
  output logic          assign_ready,
  output logic [IW-1:0] assign_unit,
  input  logic          done_valid,
  input  logic [IW-1:0] done_unit,
  input  logic          squash_valid,
  input  logic [IW-1:0] squash_unit,
  output logic          commit_valid,
  output logic [IW-1:0] commit_unit,
  output logic [IW-1:0] head_unit,
  output logic [IW-1:0] tail_unit,
  output logic [PW-1:0] occupancy,
  output logic          full,
  output logic          empty,
  output logic [UNITS-1:0] active
);

  initial begin
    if (UNITS < 2 || (1 << IW) != UNITS)
      $error("spec_task_ring: UNITS must be a power of two, at least 2");
  end

  logic [PW-1:0]    hd_q, wp_q, hd_n, wp_n;
  logic [UNITS-1:0] act_q, fin_q, act_n, fin_n, kill;
  logic [IW-1:0]    sq_off;
  logic [PW-1:0]    last_ptr;
  logic             squash_hit, take;

  assign head_unit    = hd_q[IW-1:0];
  assign occupancy    = wp_q - hd_q;
  assign full         = occupancy == PW'(UNITS);
  assign empty        = occupancy == '0;
  assign last_ptr     = wp_q - PW'(1);
  assign tail_unit    = empty ? head_unit : last_ptr[IW-1:0];
  assign assign_unit  = wp_q[IW-1:0];
  assign active       = act_q;

  assign squash_hit   = squash_valid & act_q[squash_unit];
  assign commit_valid = !squash_hit & act_q[head_unit] & fin_q[head_unit];
  assign commit_unit  = head_unit;
  assign assign_ready = !full & !squash_hit;
  assign take         = assign_valid & assign_ready;
  assign sq_off       = squash_unit - head_unit;

  for (genvar i = 0; i < UNITS; i++) begin : g_kill
    logic [IW-1:0] off;
    assign off     = IW'(i) - head_unit;
    assign kill[i] = off >= sq_off;
  end

  always_comb begin
    hd_n  = hd_q;
    wp_n  = wp_q;
    act_n = act_q;
    fin_n = fin_q;
    if (done_valid && act_q[done_unit]) fin_n[done_unit] = 1'b1;
    if (squash_hit) begin
      wp_n  = hd_q + {1'b0, sq_off};
      act_n = act_n & ~kill;
      fin_n = fin_n & ~kill;
    end else begin
      if (commit_valid) begin
        hd_n             = hd_q + PW'(1);
        act_n[head_unit] = 1'b0;
        fin_n[head_unit] = 1'b0;
      end
      if (take) begin
        wp_n               = wp_q + PW'(1);
        act_n[assign_unit] = 1'b1;
        fin_n[assign_unit] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      wp_q  <= '0;
      act_q <= '0;
      fin_q <= '0;
    end else begin
      hd_q  <= hd_n;
      wp_q  <= wp_n;
      act_q <= act_n;
      fin_q <= fin_n;
    end
  end

  AST_OCC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) == occupancy); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PW'(UNITS)); // R3

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && assign_valid && !squash_valid && !commit_valid |=> $stable(tail_unit) && full); // R3

  AST_COMMIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head_unit == IW'($past(head_unit) + 1'b1)); // R5

  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid && active[squash_unit] |=> !active[$past(squash_unit)]); // R7

  AST_SQUASH_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid && active[squash_unit] |=> $stable(head_unit)); // R8

  AST_HEAD_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> active[head_unit]); // R10

endmodule

// File: tb/spec_task_ring_test.sv
`timescale 1ns/1ps
module spec_task_ring_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic av = 1'b0, dv = 1'b0, sv = 1'b0;
  logic [1:0] du = '0, su = '0;
  logic ready, cv, full, empty;
  logic [1:0] aunit, cunit, head, tail;
  logic [2:0] occ;
  logic [N-1:0] act;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int exp_next = 0;

  always #10 clk = ~clk;

  spec_task_ring #(.UNITS(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .assign_valid(av), .assign_ready(ready), .assign_unit(aunit),
    .done_valid(dv), .done_unit(du),
    .squash_valid(sv), .squash_unit(su),
    .commit_valid(cv), .commit_unit(cunit),
    .head_unit(head), .tail_unit(tail), .occupancy(occ),
    .full(full), .empty(empty), .active(act)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic expect_eq(input string req, input int actual, input int expected);
    check(actual == expected, req, actual, expected);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    av = 1'b0; dv = 1'b0; sv = 1'b0;
  endtask

  task automatic push_task();
    expect_eq("R2 ready", int'(ready), 1);
    expect_eq("R2 assign_unit", int'(aunit), exp_next);
    av = 1'b1;
    exp_q.push_back(exp_next);
    exp_next = (exp_next + 1) % N;
    tick();
  endtask

  task automatic report_done(input int u);
    dv = 1'b1; du = 2'(u);
    tick();
  endtask

  task automatic squash(input int u, input int removed);
    sv = 1'b1; su = 2'(u);
    for (int i = 0; i < removed; i++) void'(exp_q.pop_back());
    if (removed > 0) exp_next = u;
    tick();
  endtask

  always @(negedge clk) begin
    if (rst_n && cv) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected commit", int'(cunit), -1);
      end else begin
        expect_eq("R6 commit order", int'(cunit), exp_q.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #25 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    expect_eq("R1 empty", int'(empty), 1);
    expect_eq("R1 head", int'(head), 0);
    expect_eq("R1 tail", int'(tail), 0);
    expect_eq("R1 occupancy", int'(occ), 0);
    expect_eq("R1 active", int'(act), 0);
    expect_eq("R1 ready", int'(ready), 1);
    expect_eq("R10 empty flag", int'(empty), 1);

    // R2 fill all units
    for (int i = 0; i < N; i++) begin
      push_task();
      expect_eq("R2 tail", int'(tail), i);
      expect_eq("R2 occupancy", int'(occ), i + 1);
    end
    expect_eq("R2 active", int'(act), 4'b1111);
    expect_eq("R3 full", int'(full), 1);
    expect_eq("R3 ready low", int'(ready), 0);
    av = 1'b1;
    tick();
    expect_eq("R3 occupancy held", int'(occ), 4);
    expect_eq("R3 tail held", int'(tail), 3);
    expect_eq("R3 active held", int'(act), 4'b1111);

    // R6 a younger unit finishing does not commit
    report_done(2);
    expect_eq("R6 no commit", int'(cv), 0);
    report_done(0);
    expect_eq("R5 commit strobe", int'(cv), 1);
    expect_eq("R5 commit unit", int'(cunit), 0);
    tick();
    expect_eq("R5 head advance", int'(head), 1);
    expect_eq("R5 occupancy", int'(occ), 3);
    expect_eq("R6 head not done", int'(cv), 0);
    report_done(1);
    tick();
    tick();
    expect_eq("R6 head after two commits", int'(head), 3);
    expect_eq("R6 occupancy", int'(occ), 1);
    expect_eq("R6 active", int'(act), 4'b1000);
    expect_eq("R10 empty clear", int'(empty), 0);

    // R4 wrap on assignment
    push_task();
    push_task();
    expect_eq("R4 tail wrapped", int'(tail), 1);
    expect_eq("R4 occupancy", int'(occ), 3);
    expect_eq("R4 active", int'(act), 4'b1011);

    // R7 squash from a middle unit
    squash(0, 2);
    expect_eq("R7 occupancy", int'(occ), 1);
    expect_eq("R7 tail rollback", int'(tail), 3);
    expect_eq("R7 active", int'(act), 4'b1000);
    expect_eq("R7 head kept", int'(head), 3);

    // R9 squash of an inactive unit
    squash(1, 0);
    expect_eq("R9 occupancy", int'(occ), 1);
    expect_eq("R9 tail", int'(tail), 3);
    expect_eq("R9 active", int'(act), 4'b1000);
    expect_eq("R9 head", int'(head), 3);

    // R8 squash beats commit and assign
    push_task();
    push_task();
    push_task();
    expect_eq("R3 full again", int'(full), 1);
    report_done(3);
    expect_eq("R5 head ready to commit", int'(cv), 1);
    sv = 1'b1; su = 2'd1; av = 1'b1;
    #1;
    expect_eq("R8 commit blocked", int'(cv), 0);
    expect_eq("R8 ready blocked", int'(ready), 0);
    void'(exp_q.pop_back());
    void'(exp_q.pop_back());
    exp_next = 1;
    tick();
    expect_eq("R8 head unchanged", int'(head), 3);
    expect_eq("R7 occupancy after squash", int'(occ), 2);
    expect_eq("R7 tail after squash", int'(tail), 0);
    expect_eq("R7 active after squash", int'(act), 4'b1001);
    expect_eq("R5 deferred commit", int'(cv), 1);
    tick();
    expect_eq("R4 head wrapped", int'(head), 0);
    expect_eq("R5 occupancy", int'(occ), 1);

    // R7 squash of the head empties the ring
    squash(0, 1);
    expect_eq("R7 empty", int'(empty), 1);
    expect_eq("R7 occupancy zero", int'(occ), 0);
    expect_eq("R7 head", int'(head), 0);
    expect_eq("R7 tail equals head", int'(tail), 0);
    expect_eq("R10 active clear", int'(act), 0);

    // R5 completion of an inactive unit is not recorded
    report_done(0);
    push_task();
    expect_eq("R5 stale done ignored", int'(cv), 0);
    report_done(0);
    expect_eq("R5 real done commits", int'(cv), 1);
    tick();
    expect_eq("R10 empty at end", int'(empty), 1);
    expect_eq("R6 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule